// File: doc/BRIEF.md
# UART Receive FIFO with Data-Available Interrupt

This block sits between the receiver shift logic of a 16550-style UART and the host register port. Each assembled character arriving on the write side is stored in a 16-entry, 8-bit first-in first-out buffer. The host takes bytes back out through single-cycle read strobes, and each byte appears on a registered data output.

The buffer's occupancy is compared with a programmable trigger threshold. The result drives a level-sensitive receive interrupt, with no acknowledge. A 4-bit interrupt identification code follows that interrupt. A data-ready status flag reports whether the buffer holds anything. A sticky overrun flag records characters that were lost to a full buffer. A flush control empties the buffer at once.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: `level_o` gives the number of stored characters. An accepted write raises it by one and an accepted read lowers it by one, both visible right after the clock edge. It never exceeds 16.
- R2: Characters leave in arrival order. A read of a non-empty buffer places the oldest byte on `rd_data_o` right after that clock edge.
- R3: `trig_sel_i` sets the threshold as 00 = 1, 01 = 4, 10 = 8 and 11 = 14 entries. `rx_irq_o` is high whenever `level_o` is at or above the selected threshold, and a change of selection takes effect without a clock edge.
- R4: `rx_irq_o` drops as soon as occupancy falls below the threshold. No acknowledge of any kind is needed.
- R5: `iid_o` reads 4'b0100 while `rx_irq_o` is high and 4'b0001 while it is low.
- R6: `data_ready_o` rises as soon as one character is stored. It stays high until the buffer is empty.
- R7: A write to a full buffer with no read in the same cycle discards the character and sets `overrun_o`. This flag holds until a cycle with `lsr_rd_i` high, and a new overrun in that same cycle keeps it set.
- R8: A read and a write in the same cycle leave the occupancy unchanged, including when the buffer is full. No overrun is raised in that case.
- R9: `flush_i` empties the buffer in one cycle. This drops `rx_irq_o` and `data_ready_o`, and a write in the same cycle is dropped.
- R10: A read of an empty buffer leaves `rd_data_o` holding the last byte read and keeps `level_o` at zero. A write in the same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Character strobe from receiver |
| wr_data_i | input | 8 | Received character |
| rd_en_i | input | 1 | Host byte read strobe |
| rd_data_o | output | 8 | Last byte read |
| flush_i | input | 1 | Empty the buffer |
| trig_sel_i | input | 2 | Interrupt threshold select |
| lsr_rd_i | input | 1 | Line status read, clears overrun |
| level_o | output | 5 | Current occupancy |
| data_ready_o | output | 1 | Buffer not empty |
| overrun_o | output | 1 | Sticky character-lost flag |
| rx_irq_o | output | 1 | Receive data interrupt |
| iid_o | output | 4 | Interrupt identification code |

## Verification
The hardest situation to reach is a full buffer that takes a read and a write in the same cycle. In that cycle the write must be accepted rather than counted as an overrun. A second hard case is an overrun that lands in the same cycle as the status read that would clear it. The directed stimulus fills all 16 entries and then drives both strobes in one cycle. It also issues an extra write together with `lsr_rd_i`, and then drains the buffer to confirm that the byte that was discarded never entered it.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_NEAR = 2'b11
  } trig_sel_e;

  localparam logic [3:0] IID_RDA  = 4'b0100;
  localparam logic [3:0] IID_NONE = 4'b0001;
endpackage

// File: rtl/rx_fifo_store.sv
module rx_fifo_store #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] level_o,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop_ok, push_ok;

  assign pop_ok  = pop_i && (cnt_q != '0) && !flush_i;
  // full buffer still takes a write when a read frees a slot this cycle
  assign push_ok = push_i && !flush_i && ((cnt_q != FULL_CNT) || pop_ok);
  assign drop_o  = push_i && !flush_i && !push_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (flush_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_ok) begin
      mem_q[wr_ptr_q] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      rdata_o  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok) begin
        rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
        rdata_o  <= mem_q[rd_ptr_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign level_o = cnt_q;
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import uart_rx_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       trig_sel_i,
  input  logic [CNT_W-1:0] level_i,
  output logic             irq_o,
  output logic [3:0]       iid_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] thresh;

  always_comb begin
    unique case (trig_sel_e'(trig_sel_i))
      TRIG_ONE:  thresh = CNT_W'(1);
      TRIG_QTR:  thresh = CNT_W'(DEPTH / 4);
      TRIG_HALF: thresh = CNT_W'(DEPTH / 2);
      default:   thresh = CNT_W'(DEPTH - 2);
    endcase
  end

  assign irq_o   = (level_i >= thresh);
  assign iid_o   = irq_o ? IID_RDA : IID_NONE;
  assign ready_o = (level_i != '0);
endmodule

// File: rtl/rx_ovr_flag.sv
module rx_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drop_i,
  input  logic status_rd_i,
  output logic ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ovr_o <= 1'b0;
    else if (drop_i)      ovr_o <= 1'b1;  // new loss beats the clearing read
    else if (status_rd_i) ovr_o <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             flush_i,
  input  logic [1:0]       trig_sel_i,
  input  logic             lsr_rd_i,
  output logic [CNT_W-1:0] level_o,
  output logic             data_ready_o,
  output logic             overrun_o,
  output logic             rx_irq_o,
  output logic [3:0]       iid_o
);
  logic drop;

  rx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .push_i  (wr_valid_i),
    .wdata_i (wr_data_i),
    .pop_i   (rd_en_i),
    .rdata_o (rd_data_o),
    .level_o (level_o),
    .drop_o  (drop)
  );

  rx_irq_gen #(.DEPTH(DEPTH)) i_irq (
    .trig_sel_i (trig_sel_i),
    .level_i    (level_o),
    .irq_o      (rx_irq_o),
    .iid_o      (iid_o),
    .ready_o    (data_ready_o)
  );

  rx_ovr_flag i_ovr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drop_i      (drop),
    .status_rd_i (lsr_rd_i),
    .ovr_o       (overrun_o)
  );
endmodule

// File: rtl/rx_fifo_irq_chk.sv
module rx_fifo_irq_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_valid_i,
  input logic             rd_en_i,
  input logic [WIDTH-1:0] rd_data_o,
  input logic             flush_i,
  input logic [1:0]       trig_sel_i,
  input logic             lsr_rd_i,
  input logic [CNT_W-1:0] level_o,
  input logic             data_ready_o,
  input logic             overrun_o,
  input logic             rx_irq_o,
  input logic [3:0]       iid_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  logic [CNT_W-1:0] exp_thresh;

  always_comb begin
    case (trig_sel_i)
      2'b00:   exp_thresh = CNT_W'(1);
      2'b01:   exp_thresh = CNT_W'(DEPTH / 4);
      2'b10:   exp_thresh = CNT_W'(DEPTH / 2);
      default: exp_thresh = CNT_W'(DEPTH - 2);
    endcase
  end

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= FULL_CNT);

  assert_irq_level_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o == (level_o >= exp_thresh));

  assert_irq_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_irq_o && rd_en_i && !wr_valid_i && !flush_i && level_o == exp_thresh) |=> !rx_irq_o);

  assert_iid_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iid_o == (rx_irq_o ? 4'b0100 : 4'b0001));

  assert_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o == (level_o != '0));

  assert_overrun_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !rd_en_i && !flush_i && level_o == FULL_CNT) |=> overrun_o);

  assert_overrun_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !wr_valid_i) |=> !overrun_o);

  assert_simul_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && rd_en_i && !flush_i && level_o != '0) |=> $stable(level_o));

  assert_flush_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0 && !data_ready_o));

  assert_empty_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && level_o == '0) |=> $stable(rd_data_o));
endmodule

bind uart_rx_fifo_irq rx_fifo_irq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .rd_en_i      (rd_en_i),
  .rd_data_o    (rd_data_o),
  .flush_i      (flush_i),
  .trig_sel_i   (trig_sel_i),
  .lsr_rd_i     (lsr_rd_i),
  .level_o      (level_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .rx_irq_o     (rx_irq_o),
  .iid_o        (iid_o)
);

// File: tb/test_uart_rx_fifo_irq.sv
module test_uart_rx_fifo_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, rd_en = 1'b0, flush = 1'b0, lsr_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] trig_sel = 2'b00;
  logic [7:0] rd_data;
  logic [4:0] level;
  logic       data_ready, overrun, rx_irq;
  logic [3:0] iid;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_rx_fifo_irq i_uart_rx_fifo_irq (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .flush_i(flush), .trig_sel_i(trig_sel),
    .lsr_rd_i(lsr_rd), .level_o(level), .data_ready_o(data_ready),
    .overrun_o(overrun), .rx_irq_o(rx_irq), .iid_o(iid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wv, input logic [7:0] wd, input logic rd,
                     input logic fl, input logic ls);
    @(negedge clk);
    wr_valid = wv; wr_data = wd; rd_en = rd; flush = fl; lsr_rd = ls;
    @(posedge clk);
    #1;
    wr_valid = 1'b0; rd_en = 1'b0; flush = 1'b0; lsr_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d); cyc(1'b1, d, 1'b0, 1'b0, 1'b0); endtask
  task automatic pop();                     cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0); endtask
  task automatic do_flush();                cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0); endtask

  task automatic t_reset();
    chk("R1 reset level", level, 0);
    chk("R6 reset ready", data_ready, 0);
    chk("R7 reset overrun", overrun, 0);
    chk("R3 reset irq", rx_irq, 0);
    chk("R5 reset iid", iid, 4'b0001);
  endtask

  task automatic t_order();
    do_flush();
    push(8'hA1);
    chk("R6 ready after one write", data_ready, 1);
    push(8'hB2); push(8'hC3);
    chk("R1 level after three", level, 3);
    pop(); chk("R2 first out", rd_data, 8'hA1);
    pop(); chk("R2 second out", rd_data, 8'hB2);
    chk("R6 ready while non-empty", data_ready, 1);
    pop(); chk("R2 third out", rd_data, 8'hC3);
    chk("R1 level drained", level, 0);
    chk("R6 ready clears at empty", data_ready, 0);
  endtask

  task automatic t_trigger();
    int thr [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      do_flush();
      trig_sel = 2'(s);
      for (int k = 0; k < thr[s] - 1; k++) push(8'(k));
      #1;
      chk("R3 below threshold irq", rx_irq, 0);
      chk("R5 below threshold iid", iid, 4'b0001);
      push(8'hEE);
      chk("R3 at threshold irq", rx_irq, 1);
      chk("R5 at threshold iid", iid, 4'b0100);
      pop();
      chk("R4 irq drops below threshold", rx_irq, 0);
      chk("R5 iid returns to none", iid, 4'b0001);
    end
    do_flush();
    for (int k = 0; k < 8; k++) push(8'(k));
    trig_sel = 2'b11; #1;
    chk("R3 live select to 14", rx_irq, 0);
    trig_sel = 2'b10; #1;
    chk("R3 live select to 8", rx_irq, 1);
  endtask

  task automatic t_overrun();
    do_flush();
    trig_sel = 2'b11;
    for (int k = 0; k < 16; k++) push(8'(8'h10 + k));
    chk("R1 full level", level, 16);
    chk("R7 no overrun when just full", overrun, 0);
    push(8'h5A);
    chk("R1 level capped", level, 16);
    chk("R7 overrun set", overrun, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7 overrun cleared by status read", overrun, 0);
    cyc(1'b1, 8'h66, 1'b0, 1'b0, 1'b1);
    chk("R7 set wins over status read", overrun, 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    cyc(1'b1, 8'h77, 1'b1, 1'b0, 1'b0);
    chk("R8 full read+write level", level, 16);
    chk("R8 full read+write no overrun", overrun, 0);
    chk("R8 full read+write data", rd_data, 8'h10);
    for (int k = 1; k < 16; k++) begin
      pop();
      chk("R7 dropped byte not stored", rd_data, 8'h10 + k);
    end
    pop();
    chk("R8 byte accepted while full", rd_data, 8'h77);
    chk("R1 level empty after drain", level, 0);
  endtask

  task automatic t_simul();
    do_flush();
    push(8'h31); push(8'h32);
    cyc(1'b1, 8'h33, 1'b1, 1'b0, 1'b0);
    chk("R8 level unchanged", level, 2);
    chk("R8 read data", rd_data, 8'h31);
  endtask

  task automatic t_empty_read();
    do_flush();
    push(8'h4D); pop();
    chk("R2 single read", rd_data, 8'h4D);
    pop();
    chk("R10 empty read keeps data", rd_data, 8'h4D);
    chk("R10 empty read no underflow", level, 0);
    cyc(1'b1, 8'h5E, 1'b1, 1'b0, 1'b0);
    chk("R10 write stored during empty read", level, 1);
    chk("R10 data held during empty read", rd_data, 8'h4D);
    pop();
    chk("R10 stored byte readable", rd_data, 8'h5E);
  endtask

  task automatic t_flush();
    do_flush();
    trig_sel = 2'b10;
    for (int k = 0; k < 9; k++) push(8'(k));
    chk("R3 irq before flush", rx_irq, 1);
    do_flush();
    chk("R9 level after flush", level, 0);
    chk("R9 irq after flush", rx_irq, 0);
    chk("R9 ready after flush", data_ready, 0);
    cyc(1'b1, 8'h99, 1'b0, 1'b1, 1'b0);
    chk("R9 write dropped during flush", level, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_order();
    t_trigger();
    t_overrun();
    t_simul();
    t_empty_read();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule